// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and the calendar in packed BCD. A one-cycle enable, `ref_en`, pulses at the 32.768 kHz reference rate. A prescaler counts those pulses and produces a once-per-second step. Each step advances seven separate fields: seconds, minutes, hours, date, month, year and day of week. The day count follows each month's length, and February gains its 29th day in leap years. The year field covers 2000 to 2099.

A host or serial decoder reaches the fields through a simple write port and an independent combinational read port. A mode bit in a control register selects how the hour is encoded: 24-hour, or 12-hour with a PM flag. When that bit changes, the stored hour is converted in place.

After reset the counter is halted. It stays halted until a time register is written, so a design that has lost all state never reports time that was not set. Every second step also drives a one-cycle pulse, `tick_o`, which alarm-compare logic can use.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the reads are: seconds 00, minutes 00, hour 00 (24-hour), date 01, month 01, year 00, weekday 0, control 00. No `tick_o` occurs and time does not advance until one of addresses 0 to 6 is written. A write to address 7 does not start the counter.
- R2: Address map: 0 = seconds (bits 6:0), 1 = minutes (bits 6:0), 2 = hour (bits 5:0), 3 = date (bits 5:0), 4 = month (bits 4:0), 5 = year (bits 7:0), 6 = weekday (bits 2:0), 7 = control (bit 0 = 12-hour mode). Bits outside a field are dropped on write and read back as zero.
- R3: `tick_o` is a single-cycle pulse. It follows every `PRESCALE` sampled `ref_en` pulses. Any register write clears the prescaler, so the next pulse comes exactly `PRESCALE` `ref_en` pulses after the write. A `ref_en` sampled on the same edge as a write is not counted.
- R4: On each tick, seconds roll 59 to 00 and carry into minutes. Minutes roll 59 to 00 and carry into the hour. Minutes do not change on ticks without a carry.
- R5: In 24-hour mode the hour runs 00 to 23. Going from 23 to 00 advances the date.
- R6: In 12-hour mode, hour bit 5 is the PM flag and bits 4:0 hold 12, 01 to 11. Going from 11 to 12 toggles the flag. Going from 12 to 01 keeps it. Going from 11 PM to 12 AM advances the date.
- R7: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February.
- R8: February ends at 29 when the year is divisible by 4 and at 28 otherwise. Year 00 counts as a leap year.
- R9: After December 31 the date goes to January 01 and the year advances. Year 99 wraps to 00.
- R10: The weekday counts 0 to 6. It advances on every date step and wraps from 6 to 0, regardless of month or year.
- R11: Changing the control mode bit converts the stored hour. In 24-to-12 conversion, 00 becomes 12 AM, 12 becomes 12 PM, and 13 to 23 become 01 to 11 PM. The 12-to-24 conversion is the inverse. Writing the bit with its current value leaves the hour unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 3 | Write address |
| wdata | input | 8 | Write data |
| raddr | input | 3 | Read address |
| rdata | output | 8 | Read data (combinational from `raddr`) |
| tick_o | output | 1 | One-cycle pulse on each second step |

## Verification
A wrong prescaler count shows on the first second step: `tick_o` arrives after the wrong number of `ref_en` pulses. A missed halt shows as a tick before any time write. A wrong carry or day-limit decision shows as a wrong field value read during the `tick_o` cycle of the very step that crossed the boundary. Some faults corrupt state that is only used at rare boundaries, such as a wrong leap test or a PM flag that fails to toggle. Those stay hidden until a test sets the time one or two seconds before that boundary, which is why each scenario begins just ahead of one.

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/1ps
module bcd_rtc_core #(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       wr_en,
  input  logic [2:0] waddr,
  input  logic [7:0] wdata,
  input  logic [2:0] raddr,
  output logic [7:0] rdata,
  output logic       tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [6:0] sec_q, min_q;
  logic [5:0] hr_q, date_q;
  logic [4:0] mon_q;
  logic [7:0] yr_q;
  logic [2:0] dow_q;
  logic       mode_q, run_q, tick_q;
  logic [CW-1:0] pre_q;

  function automatic logic [6:0] b2i(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [5:0] to12(input logic [5:0] h);
    logic [6:0] x;
    logic       pm;
    logic [7:0] t;
    x  = b2i({2'b00, h});
    pm = (x >= 7'd12);
    if (pm) x = x - 7'd12;
    if (x == 7'd0) x = 7'd12;
    t = i2b(x);
    return {pm, t[4:0]};
  endfunction

  function automatic logic [5:0] to24(input logic [5:0] h);
    logic [6:0] x;
    logic [7:0] t;
    x = b2i({3'b000, h[4:0]});
    if (x == 7'd12) x = 7'd0;
    if (h[5]) x = x + 7'd12;
    t = i2b(x);
    return t[5:0];
  endfunction

  logic [6:0] s_b, m_b, h24_b, h12_b, d_b, mo_b, y_b;
  logic       last, step, sec_wrap, min_wrap, day_wrap, date_wrap, mon_wrap, leap;
  logic [6:0] dim;
  logic [5:0] hr_nx;
  logic [7:0] t_sec, t_min, t_h12, t_h24, t_date, t_mon, t_yr;

  assign s_b   = b2i({1'b0, sec_q});
  assign m_b   = b2i({1'b0, min_q});
  assign h24_b = b2i({2'b00, hr_q});
  assign h12_b = b2i({3'b000, hr_q[4:0]});
  assign d_b   = b2i({2'b00, date_q});
  assign mo_b  = b2i({3'b000, mon_q});
  assign y_b   = b2i(yr_q);

  assign last     = (pre_q == LAST);
  assign step     = run_q && ref_en && !wr_en && last;
  assign sec_wrap = (s_b >= 7'd59);
  assign min_wrap = (m_b >= 7'd59);
  assign leap     = (y_b[1:0] == 2'b00);
  assign date_wrap = (d_b >= dim);
  assign mon_wrap  = (mo_b >= 7'd12);

  assign t_sec  = i2b(s_b + 7'd1);
  assign t_min  = i2b(m_b + 7'd1);
  assign t_h12  = i2b((h12_b >= 7'd12) ? 7'd1 : h12_b + 7'd1);
  assign t_h24  = i2b(h24_b + 7'd1);
  assign t_date = i2b(d_b + 7'd1);
  assign t_mon  = i2b(mo_b + 7'd1);
  assign t_yr   = i2b((y_b >= 7'd99) ? 7'd0 : y_b + 7'd1);

  always_comb begin
    case (mo_b)
      7'd2:                         dim = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:      dim = 7'd30;
      default:                      dim = 7'd31;
    endcase
  end

  always_comb begin
    if (mode_q) begin
      hr_nx    = {hr_q[5] ^ (h12_b == 7'd11), t_h12[4:0]};
      day_wrap = hr_q[5] && (h12_b == 7'd11);
    end else begin
      hr_nx    = (h24_b >= 7'd23) ? 6'h00 : t_h24[5:0];
      day_wrap = (h24_b >= 7'd23);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hr_q   <= '0;
      date_q <= 6'h01;
      mon_q  <= 5'h01;
      yr_q   <= '0;
      dow_q  <= '0;
      mode_q <= 1'b0;
      run_q  <= 1'b0;
      tick_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      tick_q <= step;
      if (wr_en) begin
        pre_q <= '0;
        if (waddr != 3'd7) run_q <= 1'b1;
        case (waddr)
          3'd0: sec_q  <= wdata[6:0];
          3'd1: min_q  <= wdata[6:0];
          3'd2: hr_q   <= wdata[5:0];
          3'd3: date_q <= wdata[5:0];
          3'd4: mon_q  <= wdata[4:0];
          3'd5: yr_q   <= wdata;
          3'd6: dow_q  <= wdata[2:0];
          default: begin
            mode_q <= wdata[0];
            if (wdata[0] != mode_q) hr_q <= wdata[0] ? to12(hr_q) : to24(hr_q);
          end
        endcase
      end else if (run_q && ref_en) begin
        pre_q <= last ? '0 : pre_q + 1'b1;
        if (last) begin
          sec_q <= sec_wrap ? 7'h00 : t_sec[6:0];
          if (sec_wrap) begin
            min_q <= min_wrap ? 7'h00 : t_min[6:0];
            if (min_wrap) begin
              hr_q <= hr_nx;
              if (day_wrap) begin
                dow_q  <= (dow_q >= 3'd6) ? 3'd0 : dow_q + 3'd1;
                date_q <= date_wrap ? 6'h01 : t_date[5:0];
                if (date_wrap) begin
                  mon_q <= mon_wrap ? 5'h01 : t_mon[4:0];
                  if (mon_wrap) yr_q <= t_yr;
                end
              end
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (raddr)
      3'd0:    rdata = {1'b0, sec_q};
      3'd1:    rdata = {1'b0, min_q};
      3'd2:    rdata = {2'b00, hr_q};
      3'd3:    rdata = {2'b00, date_q};
      3'd4:    rdata = {3'b000, mon_q};
      3'd5:    rdata = yr_q;
      3'd6:    rdata = {5'b00000, dow_q};
      default: rdata = {7'b0000000, mode_q};
    endcase
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/bcd_rtc_core_chk.sv
`timescale 1ns/1ps
module bcd_rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       tick_o,
  input logic       run_q,
  input logic       mode_q,
  input logic [6:0] sec_q,
  input logic [6:0] min_q,
  input logic [5:0] hr_q,
  input logic [5:0] date_q,
  input logic [2:0] dow_q
);
  AST_HALTED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !tick_o); // R1
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R3
  AST_WRITE_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tick_o); // R3
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(sec_q) == 7'h59) |-> (sec_q == 7'h00)); // R4
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(sec_q) != 7'h59) |-> $stable(min_q)); // R4
  AST_MIDNIGHT_24: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !mode_q && $past(hr_q) == 6'h23 && $past(min_q) == 7'h59 && $past(sec_q) == 7'h59)
      |-> (hr_q == 6'h00)); // R5
  AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && mode_q && $past(hr_q) == 6'h11 && $past(min_q) == 7'h59 && $past(sec_q) == 7'h59)
      |-> (hr_q == 6'h32)); // R6
  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(dow_q) == 3'd6 && $past(date_q) != date_q) |-> (dow_q == 3'd0)); // R10
endmodule

bind bcd_rtc_core bcd_rtc_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick_o(tick_o), .run_q(run_q),
  .mode_q(mode_q), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q),
  .date_q(date_q), .dow_q(dow_q)
);

// File: tb/bcd_rtc_core_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb_top;
  localparam int PRE = 4;

  logic clk = 1'b0, rst_n = 1'b0, ref_en = 1'b0, wr_en = 1'b0;
  logic [2:0] waddr = '0, raddr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic tick_o;

  int checks = 0, errors = 0, ticks_seen = 0, ref_cnt = 0;
  bit done = 1'b0;

  logic [55:0] exp_q[$];
  string       tag_q[$];

  int m_sec, m_min, m_hr, m_date, m_mon, m_yr, m_dow, m_mode;

  bcd_rtc_core #(.PRESCALE(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en), .waddr(waddr),
    .wdata(wdata), .raddr(raddr), .rdata(rdata), .tick_o(tick_o)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    ref_en = ~ref_en;
  end

  function automatic logic [7:0] tobcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] hour_enc(input int h, input int mode);
    int x;
    if (mode == 0) return tobcd(h);
    x = h % 12;
    if (x == 0) x = 12;
    return tobcd(x) | ((h >= 12) ? 8'h20 : 8'h00);
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] model_pack();
    return {tobcd(m_sec), tobcd(m_min), hour_enc(m_hr, m_mode), tobcd(m_date),
            tobcd(m_mon), tobcd(m_yr), tobcd(m_dow)};
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0; m_date++; m_dow = (m_dow + 1) % 7;
          if (m_date > mdays(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    raddr = a;
    #0.2;
    d = rdata;
  endtask

  task automatic set_time(input int yr, input int mo, input int dt, input int dw,
                          input int hr, input int mi, input int se);
    m_yr = yr; m_mon = mo; m_date = dt; m_dow = dw; m_hr = hr; m_min = mi; m_sec = se;
    wr(3'd0, tobcd(se));
    wr(3'd1, tobcd(mi));
    wr(3'd2, hour_enc(hr, m_mode));
    wr(3'd3, tobcd(dt));
    wr(3'd4, tobcd(mo));
    wr(3'd5, tobcd(yr));
    wr(3'd6, tobcd(dw));
  endtask

  task automatic expect_ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      model_step();
      exp_q.push_back(model_pack());
      tag_q.push_back(tag);
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: compares every second step against the scoreboard
  always @(negedge clk) begin
    if (tick_o && !done) begin
      logic [55:0] got;
      ticks_seen++;
      for (int i = 0; i < 7; i++) begin
        raddr = 3'(i);
        #0.2;
        got[55 - 8*i -: 8] = rdata;
      end
      if (exp_q.size() == 0) begin
        chk("R1 unexpected tick", {8'h0, got}, 64'h0);
      end else begin
        chk(tag_q.pop_front(), {8'h0, got}, {8'h0, exp_q.pop_front()});
      end
    end
  end

  // R3: interval between a write or tick and the next tick
  always @(clk) begin
    if (clk) begin
      if (rst_n && wr_en) ref_cnt = 0;
      else if (ref_en) ref_cnt++;
    end else if (tick_o && !done) begin
      chk("R3 ref pulses per tick", 64'(ref_cnt), 64'(PRE));
      ref_cnt = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    m_mode = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd0, v); chk("R1 reset seconds", v, 8'h00);
    rd(3'd1, v); chk("R1 reset minutes", v, 8'h00);
    rd(3'd2, v); chk("R1 reset hour", v, 8'h00);
    rd(3'd3, v); chk("R1 reset date", v, 8'h01);
    rd(3'd4, v); chk("R1 reset month", v, 8'h01);
    rd(3'd5, v); chk("R1 reset year", v, 8'h00);
    rd(3'd6, v); chk("R1 reset weekday", v, 8'h00);
    rd(3'd7, v); chk("R1 reset control", v, 8'h00);
    repeat (40) @(negedge clk);
    chk("R1 halted after reset", 64'(ticks_seen), 64'd0);

    // R11 / R2 / R1: control write converts hour, does not start the clock
    wr(3'd7, 8'hFF);
    rd(3'd7, v); chk("R2 control field mask", v, 8'h01);
    rd(3'd2, v); chk("R11 00 to 12 AM", v, 8'h12);
    repeat (40) @(negedge clk);
    chk("R1 control write keeps halt", 64'(ticks_seen), 64'd0);
    wr(3'd7, 8'h00);
    rd(3'd2, v); chk("R11 12 AM to 00", v, 8'h00);
    wr(3'd7, 8'h00);
    rd(3'd2, v); chk("R11 same-mode write keeps hour", v, 8'h00);

    // R2 field masks (starts the clock; time is re-set right after)
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk("R2 seconds mask", v, 8'h7F);
    wr(3'd6, 8'hFF);
    rd(3'd6, v); chk("R2 weekday mask", v, 8'h07);

    // R4 second/minute carries
    set_time(24, 6, 15, 2, 10, 58, 58);
    expect_ticks(3, "R4 seconds/minutes carry");
    // R5 + R10 midnight in 24-hour mode, weekday 6 wraps
    set_time(24, 6, 15, 6, 23, 59, 58);
    expect_ticks(3, "R5 R10 midnight and weekday wrap");
    // R7 month lengths
    set_time(23, 4, 30, 1, 23, 59, 59);
    expect_ticks(1, "R7 April 30 wraps");
    set_time(23, 1, 30, 1, 23, 59, 59);
    expect_ticks(1, "R7 January 30 to 31");
    set_time(23, 1, 31, 1, 23, 59, 59);
    expect_ticks(1, "R7 January 31 wraps");
    // R8 February
    set_time(23, 2, 28, 3, 23, 59, 59);
    expect_ticks(1, "R8 Feb 28 common year");
    set_time(24, 2, 28, 3, 23, 59, 59);
    expect_ticks(1, "R8 Feb 28 leap year");
    set_time(24, 2, 29, 4, 23, 59, 59);
    expect_ticks(1, "R8 Feb 29 wraps");
    set_time(0, 2, 28, 4, 23, 59, 59);
    expect_ticks(1, "R8 year 00 is leap");
    // R9 year end
    set_time(99, 12, 31, 5, 23, 59, 58);
    expect_ticks(2, "R9 Dec 31 year 99 wraps");
    set_time(41, 12, 31, 0, 23, 59, 59);
    expect_ticks(1, "R9 year advances");

    // R11 conversion of a running time, then R6 12-hour stepping
    set_time(30, 3, 10, 2, 13, 20, 0);
    wr(3'd7, 8'h01); m_mode = 1;
    rd(3'd2, v); chk("R11 13 to 01 PM", v, 8'h21);
    expect_ticks(2, "R11 12-hour after conversion");
    set_time(30, 3, 10, 2, 11, 59, 58);
    expect_ticks(2, "R6 11 AM to 12 PM");
    set_time(30, 3, 10, 2, 12, 59, 59);
    expect_ticks(1, "R6 12 PM to 01 PM");
    set_time(30, 3, 10, 6, 23, 59, 58);
    expect_ticks(3, "R6 R10 11 PM to 12 AM with date step");
    set_time(30, 3, 10, 2, 0, 59, 59);
    expect_ticks(1, "R6 12 AM to 01 AM");
    wr(3'd7, 8'h00); m_mode = 0;
    rd(3'd2, v); chk("R11 01 AM to 01", v, 8'h01);
    expect_ticks(1, "R11 24-hour after conversion");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule